// File: doc/BRIEF.md
# I2C Master Command and Byte Engine

This block is the bus-facing core of a register-programmed I2C master. Software reaches it through three word-wide registers: a control register, a data register and a status register. Through the control register it switches the engine on and asks for a START, a repeated START or a STOP. Each of these conditions is a separate command and raises its own completion event. Writing a byte to the data register sends that byte on the bus. The engine then samples the target's acknowledge bit and records the result.

The engine drives SCL and SDA in open-drain fashion. Each line has an active-high pull-low enable and is otherwise released. Bus timing comes from one divider parameter, `HALF_PER`, which is the number of clock cycles per bus step. Once a condition or byte is done, the engine parks the bus in a known state and waits for the next command. A NAK does not stop the bus. Software decides what to do next.

Register map (word index on `bus_addr`):
- Address 0, control: bit 0 enable; bits [2:1] command (0 none, 1 START/RESTART, 2 STOP, 3 none); bit 3 condition select on write and ACK/NAK result on read.
- Address 1, data: bits [7:0] byte to send.
- Address 2, status.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0, the control register reads 0 and the status register reads 0x02.
- R2: A control write with enable=1 and command=1 runs a START/RESTART sequence, one step per `HALF_PER` cycles. After 2 steps both lines are released. After 3 steps SDA is pulled low while SCL is still released. After 4 steps SCL is also pulled low and the command completes, setting status bit 3 (session done).
- R3: A control write with enable=1 and command=2 runs a STOP in 3 steps. The first step pulls SDA low, the second releases SCL and the third releases SDA. The command then completes with both lines released and status bit 3 set.
- R4: With the engine enabled, a data write sends bits [7:0] MSB first over 8 SCL pulses. A ninth SCL pulse follows with SDA released for the acknowledge. Each bit takes 3 steps, so the byte completes 27 steps after the write, setting status bit 3.
- R5: Control bit 3 reads back the value last written to it by an accepted control write. When a byte completes, it changes to the sampled acknowledge: 0 for ACK (SDA low) and 1 for NAK.
- R6: A NAK on a byte sets status bit 0 (no-ACK). An ACK leaves it clear. After a NAK the engine generates no STOP, and SCL stays held low.
- R7: Status bits 3 and 0 are cleared by writing 1 to them at address 2. Writing 0 leaves them unchanged.
- R8: Status bit 7 (command busy) is 1 from the cycle after an accepted command or data write until the cycle the operation completes. Control and data writes made while busy are ignored.
- R9: A command written with enable=0, a command value of 3, or a data write while the engine is disabled starts nothing. The lines do not move, busy stays 0 and the data register keeps its old value.
- R10: Status bits 31:8, 6, 5, 4 and 2 read 0. Status bit 1 reads 1 unless a byte is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index for both reads and writes |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for `bus_addr`, combinational |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
An accepted write at clock edge E raises busy from E onward, and each bus step lands on edge E + k·HALF_PER. START and RESTART therefore finish at E+4·HALF_PER, STOP at E+3·HALF_PER and a byte at E+27·HALF_PER. On the finishing edge, busy falls and the session-done and no-ACK bits update together. The bench counts falling clock edges from the write and reads the status one cycle before and exactly at each finishing edge. Line levels for START are checked at the intermediate step edges. A bench-side target records the SDA level at every SCL rise to rebuild the transmitted byte. It answers ACK or NAK on request.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  // Bus operation currently owned by the sequencer
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_COND = 2'd1,   // START or repeated START
    OP_STOP = 2'd2,
    OP_BYTE = 2'd3
  } op_e;

  // Command field encodings in the control register
  localparam logic [1:0] CMD_NONE  = 2'd0;
  localparam logic [1:0] CMD_COND  = 2'd1;
  localparam logic [1:0] CMD_STOP  = 2'd2;

  // Register word indices
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_DATA = 1;
  localparam int unsigned ADDR_STAT = 2;

  // Status bit positions
  localparam int unsigned ST_BUSY  = 7;
  localparam int unsigned ST_DONE  = 3;
  localparam int unsigned ST_TXE   = 1;
  localparam int unsigned ST_NACK  = 0;

  localparam int unsigned BYTE_W   = 8;

endpackage

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int unsigned HALF_PER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PER - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_bus_seq.sv
module i2c_bus_seq
  import i2c_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch,
  input  op_e               launch_op,
  input  logic [BYTE_W-1:0] launch_byte,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output op_e               op,
  output logic              done,
  output logic              done_nack
);
  localparam int unsigned BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

  op_e               op_q, op_d;
  logic [1:0]        step_q, step_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              scl_q, scl_d, sda_q, sda_d;
  logic              ack_slot;

  assign ack_slot  = (bit_q == ACK_SLOT);
  assign busy      = (op_q != OP_IDLE);
  assign op        = op_q;
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;
  assign done_nack = sda_in;

  always_comb begin
    op_d    = op_q;
    step_d  = step_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    done    = 1'b0;
    if (op_q == OP_IDLE) begin
      if (launch) begin
        op_d    = launch_op;
        step_d  = '0;
        bit_d   = '0;
        shift_d = launch_byte;
      end
    end else if (tick) begin
      step_d = step_q + 2'd1;
      unique case (op_q)
        OP_COND: begin
          unique case (step_q)
            2'd0:    sda_d = 1'b0;
            2'd1:    scl_d = 1'b0;
            2'd2:    sda_d = 1'b1;
            default: begin scl_d = 1'b1; done = 1'b1; end
          endcase
        end
        OP_STOP: begin
          unique case (step_q)
            2'd0:    sda_d = 1'b1;
            2'd1:    scl_d = 1'b0;
            default: begin sda_d = 1'b0; done = 1'b1; end
          endcase
        end
        OP_BYTE: begin
          unique case (step_q)
            2'd0:    sda_d = ack_slot ? 1'b0 : ~shift_q[BYTE_W-1];
            2'd1:    scl_d = 1'b0;
            default: begin
              scl_d   = 1'b1;
              step_d  = '0;
              shift_d = {shift_q[BYTE_W-2:0], 1'b0};
              if (ack_slot) done = 1'b1;
              else          bit_d = bit_q + 1'b1;
            end
          endcase
        end
        default: ;
      endcase
      if (done) op_d = OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      step_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      op_q    <= op_d;
      step_q  <= step_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
    end
  end
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
  import i2c_eng_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  op_e               op,
  input  logic              done,
  input  logic              done_nack,
  output logic              launch,
  output op_e               launch_op,
  output logic [BYTE_W-1:0] launch_byte,
  output logic              sess_done,
  output logic [BYTE_W-1:0] data_val
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic              en_q, en_d;
  logic [1:0]        cmd_q, cmd_d;
  logic              sel_q, sel_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              done_q, done_d;
  logic              nack_q, nack_d;
  logic              wr_ctrl, wr_data, wr_stat, byte_end;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[BUS_W-1:BYTE_W];

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL) && !busy;
  assign wr_data  = bus_wr && (bus_addr == A_DATA) && !busy && en_q;
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);
  assign byte_end = done && (op == OP_BYTE);

  // Launch decode
  always_comb begin
    launch      = 1'b0;
    launch_op   = OP_IDLE;
    launch_byte = bus_wdata[BYTE_W-1:0];
    if (wr_data) begin
      launch    = 1'b1;
      launch_op = OP_BYTE;
    end else if (wr_ctrl && bus_wdata[0]) begin
      if (bus_wdata[2:1] == CMD_COND) begin
        launch    = 1'b1;
        launch_op = OP_COND;
      end else if (bus_wdata[2:1] == CMD_STOP) begin
        launch    = 1'b1;
        launch_op = OP_STOP;
      end
    end
  end

  // Register next state
  always_comb begin
    en_d   = en_q;
    cmd_d  = cmd_q;
    sel_d  = sel_q;
    data_d = data_q;
    done_d = done_q;
    nack_d = nack_q;
    if (wr_ctrl) begin
      en_d  = bus_wdata[0];
      cmd_d = bus_wdata[2:1];
      sel_d = bus_wdata[3];
    end
    if (byte_end) sel_d = done_nack;
    if (wr_data) data_d = bus_wdata[BYTE_W-1:0];
    if (wr_stat && bus_wdata[ST_DONE]) done_d = 1'b0;
    if (wr_stat && bus_wdata[ST_NACK]) nack_d = 1'b0;
    if (done) done_d = 1'b1;
    if (byte_end && done_nack) nack_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cmd_q  <= CMD_NONE;
      sel_q  <= 1'b0;
      data_q <= '0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      cmd_q  <= cmd_d;
      sel_q  <= sel_d;
      data_q <= data_d;
      done_q <= done_d;
      nack_q <= nack_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: bus_rdata[3:0] = {sel_q, cmd_q, en_q};
      A_DATA: bus_rdata[BYTE_W-1:0] = data_q;
      A_STAT: begin
        bus_rdata[ST_BUSY] = busy;
        bus_rdata[ST_DONE] = done_q;
        bus_rdata[ST_TXE]  = (op != OP_BYTE);
        bus_rdata[ST_NACK] = nack_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign sess_done = done_q;
  assign data_val  = data_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_eng_pkg::*;
#(
  parameter int unsigned HALF_PER = 4,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned BUS_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic              tick, busy, done, done_nack, launch, sess_done;
  op_e               op, launch_op;
  logic [BYTE_W-1:0] launch_byte, data_val;

  i2c_tick_gen #(.HALF_PER(HALF_PER)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  i2c_bus_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .launch      (launch),
    .launch_op   (launch_op),
    .launch_byte (launch_byte),
    .sda_in      (sda_in),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .busy        (busy),
    .op          (op),
    .done        (done),
    .done_nack   (done_nack)
  );

  i2c_reg_file #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .busy        (busy),
    .op          (op),
    .done        (done),
    .done_nack   (done_nack),
    .launch      (launch),
    .launch_op   (launch_op),
    .launch_byte (launch_byte),
    .sess_done   (sess_done),
    .data_val    (data_val)
  );
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk
  import i2c_eng_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              busy,
  input op_e               op,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              sess_done,
  input logic [BYTE_W-1:0] data_val
);
  // R8: completion always leaves the session-done flag set
  a_r8_done_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sess_done);

  // R8: data register holds while a write arrives during busy
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == ADDR_W'(ADDR_DATA)) |=> $stable(data_val));

  // R6: a finished byte never releases SCL on its own
  a_r6_no_auto_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op) == OP_BYTE && op == OP_IDLE) |-> scl_oe);

  // R4: SDA is steady while SCL is released inside a byte
  a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BYTE && $past(op) == OP_BYTE && !$past(scl_oe)) |-> $stable(sda_oe));

  // R10: reserved status bits read zero
  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(ADDR_STAT)) |->
      (bus_rdata[BUS_W-1:8] == '0 && bus_rdata[6:4] == 3'd0 && !bus_rdata[2]));
endmodule

bind i2c_byte_master i2c_byte_master_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .op        (op),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .sess_done (sess_done),
  .data_val  (data_val)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;

  logic        clk, rst_n, bus_wr, sda_in, scl_oe, sda_oe;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ack_pull;
  logic [8:0]  cap;
  int          cap_n;
  int          n_chk, n_fail;
  logic        finished;

  i2c_byte_master #(.HALF_PER(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Target model: answers ACK by pulling SDA when ack_pull is set
  assign sda_in = ~sda_oe & ~ack_pull;

  // Record the SDA level the master presents at each SCL rise
  always @(negedge scl_oe) begin
    if (rst_n) begin
      cap   = {cap[7:0], ~sda_oe};
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(2, s);
      if (!s[7]) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 scl_oe", {31'd0, scl_oe}, 0);
    chk("R1 sda_oe", {31'd0, sda_oe}, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1/R10 status", v, 32'h02);
  endtask

  task automatic t_start();
    logic [31:0] v;
    wr(0, 32'h3);
    cyc(2*H);
    chk("R2 step2 scl released", {31'd0, scl_oe}, 0);
    chk("R2 step2 sda released", {31'd0, sda_oe}, 0);
    cyc(H);
    chk("R2 step3 sda low", {31'd0, sda_oe}, 1);
    chk("R2 step3 scl high", {31'd0, scl_oe}, 0);
    cyc(H-1);
    rd(2, v); chk("R8 busy before end", {31'd0, v[7]}, 1);
    cyc(1);
    rd(2, v); chk("R2 status at end", v, 32'h0A);
    chk("R2 scl held low", {31'd0, scl_oe}, 1);
    rd(0, v); chk("R5 ctrl start select", v, 32'h3);
    wr(2, 32'h9); wr(0, 32'h1);
  endtask

  task automatic t_byte_ack();
    logic [31:0] v;
    ack_pull = 1'b1; cap_n = 0;
    wr(1, 32'hA5);
    cyc(27*H-1);
    rd(2, v);
    chk("R8 busy during byte", {31'd0, v[7]}, 1);
    chk("R10 txe low in flight", {31'd0, v[1]}, 0);
    cyc(1);
    rd(2, v); chk("R4/R6 status after ACK", v, 32'h0A);
    chk("R4 scl pulses", cap_n, 9);
    chk("R4 bits MSB first", {23'd0, cap}, {23'd0, 8'hA5, 1'b1});
    rd(0, v); chk("R5 ack reads 0", v, 32'h1);
    ack_pull = 1'b0;
  endtask

  task automatic t_w1c_done();
    logic [31:0] v;
    wr(2, 32'h0);
    rd(2, v); chk("R7 zero write keeps", v, 32'h0A);
    wr(2, 32'h8);
    rd(2, v); chk("R7 one clears done", v, 32'h02);
  endtask

  task automatic t_busy_nak();
    logic [31:0] v;
    cap_n = 0;
    wr(1, 32'h3C);
    cyc(3);
    wr(1, 32'hFF);
    wr(0, 32'h5);
    wait_idle();
    rd(1, v); chk("R8 data write ignored", v, 32'h3C);
    chk("R8 sent byte unchanged", {23'd0, cap}, {23'd0, 8'h3C, 1'b1});
    rd(0, v); chk("R8/R5 ctrl: stop ignored, nak=1", v, 32'h9);
    rd(2, v); chk("R6 nack status", v, 32'h0B);
    cyc(10);
    chk("R6 no stop: scl low", {31'd0, scl_oe}, 1);
    chk("R6 no stop: sda released", {31'd0, sda_oe}, 0);
  endtask

  task automatic t_w1c_nack();
    logic [31:0] v;
    wr(2, 32'h1);
    rd(2, v); chk("R7 clear nack only", v, 32'h0A);
    wr(2, 32'h8);
    rd(2, v); chk("R7 clear done", v, 32'h02);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(0, 32'hB);
    cyc(4*H);
    rd(2, v); chk("R2 restart done", v, 32'h0A);
    chk("R2 restart lines", {30'd0, scl_oe, sda_oe}, 3);
    rd(0, v); chk("R5 restart select reads 1", v, 32'hB);
    wr(2, 32'h8); wr(0, 32'h1);
    rd(0, v); chk("R5 select rewritten 0", v, 32'h1);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(0, 32'h5);
    cyc(3*H-1);
    rd(2, v); chk("R3/R8 busy before stop end", {31'd0, v[7]}, 1);
    cyc(1);
    rd(2, v); chk("R3 stop status", v, 32'h0A);
    chk("R3 lines released", {30'd0, scl_oe, sda_oe}, 0);
    wr(2, 32'h8); wr(0, 32'h1);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(0, 32'h2);
    cyc(1);
    rd(2, v); chk("R9 disabled cmd no busy", v, 32'h02);
    wr(1, 32'h77);
    cyc(1);
    rd(2, v); chk("R9 disabled data no busy", v, 32'h02);
    rd(1, v); chk("R9 data kept", v, 32'h3C);
    wr(0, 32'h7);
    cyc(2*H);
    rd(2, v); chk("R9 cmd 3 no action", v, 32'h02);
    chk("R9 lines idle", {30'd0, scl_oe, sda_oe}, 0);
  endtask

  initial begin
    finished = 1'b0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cap = '0; cap_n = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; ack_pull = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_start();
    t_byte_ack();
    t_w1c_done();
    t_busy_nak();
    t_w1c_nack();
    t_restart();
    t_stop();
    t_disabled();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule